// File: doc/BRIEF.md
# Dual-Channel Interrupt Vector Controller

This block decides which interrupt source of a two-channel serial controller is pending and which one is in service. It also drives the combined interrupt request line. Each channel, A and B, reports receive events, transmit events and a break status level. Software clears interrupts through three per-channel strobes: clear receive, clear transmit, and reset of the highest source under service. Per-channel configuration selects the following:
- whether transmit interrupts reach the request line;
- the receive interrupt mode;
- whether break reaches the request line;
- which of two vector encodings is written.

The block keeps a single shared modified vector and a single shared pending register for both channels. On each channel only one of receive or transmit can be under service at a time. A request that arrives while the other source of the same channel is in service only raises its pending flag. When the source in service is cleared, a request that is still pending on that channel is raised again and takes service.

Every channel-indexed port uses bit 1 for channel A and bit 0 for channel B. All updates happen at the clock edge that samples the strobe. Reset is synchronous and active high.

Top module: `dual_chan_irq_vec`

## Requirements
- R1: While `rst` is high, all pending and in-service flags clear at the next edge, and after that edge `vector` is 0x00, `pending` is 0x00 and `irq` is 0.
- R2: `irq` is a register. It is 1 after an edge if, for either channel, at least one of these holds after that edge's update:
  - `tx_int_en` is set and transmit is pending;
  - that channel's receive mode is 2'b01 or 2'b10 and receive is pending;
  - `brk_int_en` and `brk_st` are both set at that edge.
  
  Receive modes 2'b00 and 2'b11 never raise `irq`.
- R3: A receive event enters service only if that channel's transmit is not in service, and a transmit event enters service only if that channel's receive is not in service. Otherwise only the pending flag is set. When receive and transmit events of one channel arrive in the same cycle, receive takes service.
- R4: With `vec_hi` low for the channel that writes the vector, the codes are:
  - A receive 0x0C;
  - A transmit 0x08;
  - B receive 0x04;
  - B transmit 0x00;
  - none 0x06.
- R5: With `vec_hi` high, the codes are:
  - A receive 0x30;
  - A transmit 0x10;
  - B receive 0x20;
  - B transmit 0x00;
  - none 0x60.
- R6: The `pending` bits are:
  - bit 5 A receive;
  - bit 4 A transmit;
  - bit 2 B receive;
  - bit 1 B transmit.
  
  Bits 3 and 0 (external/status) always read 0.
- R7: A clear clears that source's pending and in-service flags and writes the no-interrupt code. If the other source of the same channel is still pending, it then takes service and writes its own code. Within one channel, clear receive takes priority over clear transmit, which takes priority over reset-highest.
- R8: Reset-highest clears receive if receive is in service, otherwise transmit if transmit is in service. With neither in service it changes nothing.
- R9: Within one cycle, channel A's actions apply before channel B's, so a vector written by B wins. Within a channel, the clear commands apply before new events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_rx | input | 2 | Receive event strobe per channel |
| ev_tx | input | 2 | Transmit event strobe per channel |
| brk_st | input | 2 | Break status level per channel |
| cmd_clr_rx | input | 2 | Clear receive interrupt strobe |
| cmd_clr_tx | input | 2 | Clear transmit interrupt strobe |
| cmd_rst_ius | input | 2 | Reset highest under service strobe |
| tx_int_en | input | 2 | Transmit interrupt enable |
| brk_int_en | input | 2 | Break interrupt enable |
| vec_hi | input | 2 | Status-high vector encoding select |
| rx_mode_a | input | 2 | Channel A receive interrupt mode |
| rx_mode_b | input | 2 | Channel B receive interrupt mode |
| irq | output | 1 | Combined interrupt request |
| vector | output | 8 | Shared modified vector |
| pending | output | 6 | Shared interrupt pending bits |

## Verification
Three kinds of events can collide in one cycle:
- a receive event and a transmit event on the same channel;
- a clear and a new event on the same channel;
- events on both channels, which both write the shared vector.

The table rows drive each of these pairs in a single strobe cycle. The resulting vector, pending bits and request line are judged one edge later against the ordering rules. Those rules are: receive over transmit, clear before event, and channel B after channel A.

// File: rtl/dual_chan_irq_vec.sv
module dual_chan_irq_vec (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ev_rx,
  input  logic [1:0] ev_tx,
  input  logic [1:0] brk_st,
  input  logic [1:0] cmd_clr_rx,
  input  logic [1:0] cmd_clr_tx,
  input  logic [1:0] cmd_rst_ius,
  input  logic [1:0] tx_int_en,
  input  logic [1:0] brk_int_en,
  input  logic [1:0] vec_hi,
  input  logic [1:0] rx_mode_a,
  input  logic [1:0] rx_mode_b,
  output logic       irq,
  output logic [7:0] vector,
  output logic [5:0] pending
);

  logic [1:0] rx_p, tx_p, rx_s, tx_s;
  logic [1:0] n_rxp, n_txp, n_rxs, n_txs;
  logic [7:0] vec_q, n_vec;
  logic       irq_q, n_irq;
  logic [1:0] rx_ok;

  function automatic logic [7:0] src_code(input logic is_a, input logic is_rx, input logic hi);
    if (is_rx) return is_a ? (hi ? 8'h30 : 8'h0C) : (hi ? 8'h20 : 8'h04);
    return is_a ? (hi ? 8'h10 : 8'h08) : 8'h00;
  endfunction

  function automatic logic [7:0] idle_code(input logic hi);
    return hi ? 8'h60 : 8'h06;
  endfunction

  assign rx_ok[1] = (rx_mode_a == 2'b01) || (rx_mode_a == 2'b10);
  assign rx_ok[0] = (rx_mode_b == 2'b01) || (rx_mode_b == 2'b10);

  always_comb begin
    n_rxp = rx_p;
    n_txp = tx_p;
    n_rxs = rx_s;
    n_txs = tx_s;
    n_vec = vec_q;
    for (int c = 1; c >= 0; c--) begin
      if (cmd_clr_rx[c] || (!cmd_clr_tx[c] && cmd_rst_ius[c] && n_rxs[c])) begin
        n_rxp[c] = 1'b0;
        n_rxs[c] = 1'b0;
        n_vec = idle_code(vec_hi[c]);
        if (n_txp[c]) begin
          n_txs[c] = 1'b1;
          n_vec = src_code(c == 1, 1'b0, vec_hi[c]);
        end
      end else if (cmd_clr_tx[c] || (cmd_rst_ius[c] && n_txs[c])) begin
        n_txp[c] = 1'b0;
        n_txs[c] = 1'b0;
        n_vec = idle_code(vec_hi[c]);
        if (n_rxp[c]) begin
          n_rxs[c] = 1'b1;
          n_vec = src_code(c == 1, 1'b1, vec_hi[c]);
        end
      end
      if (ev_rx[c]) begin
        n_rxp[c] = 1'b1;
        if (!n_txs[c]) begin
          n_rxs[c] = 1'b1;
          n_vec = src_code(c == 1, 1'b1, vec_hi[c]);
        end
      end
      if (ev_tx[c]) begin
        n_txp[c] = 1'b1;
        if (!n_rxs[c]) begin
          n_txs[c] = 1'b1;
          n_vec = src_code(c == 1, 1'b0, vec_hi[c]);
        end
      end
    end
  end

  assign n_irq = |((tx_int_en & n_txp) | (rx_ok & n_rxp) | (brk_int_en & brk_st));

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_p  <= '0;
      tx_p  <= '0;
      rx_s  <= '0;
      tx_s  <= '0;
      vec_q <= 8'h00;
      irq_q <= 1'b0;
    end else begin
      rx_p  <= n_rxp;
      tx_p  <= n_txp;
      rx_s  <= n_rxs;
      tx_s  <= n_txs;
      vec_q <= n_vec;
      irq_q <= n_irq;
    end
  end

  assign irq     = irq_q;
  assign vector  = vec_q;
  assign pending = {rx_p[1], tx_p[1], 1'b0, rx_p[0], tx_p[0], 1'b0};

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk)
    if (rst_q === 1'b1)
      AST_RST_STATE: assert (!irq && vector == 8'h00 && pending == 6'h00); // R1

  AST_SVC_EXCL: assert property (@(posedge clk) disable iff (rst) (rx_s & tx_s) == 2'b00); // R3
  AST_SVC_PEND: assert property (@(posedge clk) disable iff (rst) ((rx_s & ~rx_p) | (tx_s & ~tx_p)) == 2'b00); // R3
  AST_CLR_RX_A: assert property (@(posedge clk) disable iff (rst) (cmd_clr_rx[1] && !ev_rx[1]) |=> !pending[5]); // R7
  AST_CLR_TX_B: assert property (@(posedge clk) disable iff (rst) (cmd_clr_tx[0] && !cmd_clr_rx[0] && !ev_tx[0]) |=> !pending[1]); // R7
  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (rst) irq |-> ((|pending) || $past(|(brk_st & brk_int_en)))); // R2

endmodule

// File: tb/tb_dual_chan_irq_vec.sv
module tb_dual_chan_irq_vec;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] ev_rx = '0, ev_tx = '0, brk_st = '0, cmd_clr_rx = '0, cmd_clr_tx = '0, cmd_rst_ius = '0;
  logic [1:0] tx_int_en = 2'b11, brk_int_en = '0, vec_hi = '0, rx_mode_a = 2'b01, rx_mode_b = 2'b10;
  logic       irq;
  logic [7:0] vector;
  logic [5:0] pending;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_chan_irq_vec dut (.*);

  // {rx, tx, clr_rx, clr_tx, rst_ius, hi} -> {vector, pending, irq}; bit1 = A, bit0 = B
  localparam logic [26:0] TBL [18] = '{
    {2'b10,2'b00,2'b00,2'b00,2'b00,2'b00, 8'h0C, 6'h20, 1'b1}, // R4 R6 A rx
    {2'b00,2'b10,2'b00,2'b00,2'b00,2'b00, 8'h0C, 6'h30, 1'b1}, // R3 tx only pends
    {2'b00,2'b00,2'b00,2'b00,2'b10,2'b00, 8'h08, 6'h10, 1'b1}, // R8 R7 re-raise tx
    {2'b00,2'b00,2'b00,2'b10,2'b00,2'b00, 8'h06, 6'h00, 1'b0}, // R7 clear tx
    {2'b00,2'b01,2'b00,2'b00,2'b00,2'b00, 8'h00, 6'h02, 1'b1}, // R4 B tx
    {2'b01,2'b00,2'b00,2'b00,2'b00,2'b00, 8'h00, 6'h06, 1'b1}, // R3 B rx pends
    {2'b00,2'b00,2'b00,2'b01,2'b00,2'b00, 8'h04, 6'h04, 1'b1}, // R7 B rx re-raised
    {2'b00,2'b00,2'b01,2'b00,2'b00,2'b00, 8'h06, 6'h00, 1'b0}, // R7
    {2'b10,2'b10,2'b00,2'b00,2'b00,2'b11, 8'h30, 6'h30, 1'b1}, // R3 R5 same cycle
    {2'b00,2'b00,2'b10,2'b00,2'b00,2'b11, 8'h10, 6'h10, 1'b1}, // R5 R7
    {2'b00,2'b00,2'b00,2'b10,2'b00,2'b11, 8'h60, 6'h00, 1'b0}, // R5
    {2'b01,2'b00,2'b00,2'b00,2'b00,2'b11, 8'h20, 6'h04, 1'b1}, // R5
    {2'b00,2'b01,2'b01,2'b00,2'b00,2'b11, 8'h00, 6'h02, 1'b1}, // R9 clear before event
    {2'b00,2'b00,2'b00,2'b00,2'b01,2'b11, 8'h60, 6'h00, 1'b0}, // R8
    {2'b11,2'b00,2'b00,2'b00,2'b00,2'b00, 8'h04, 6'h24, 1'b1}, // R9 B wins vector
    {2'b00,2'b00,2'b00,2'b00,2'b10,2'b00, 8'h06, 6'h04, 1'b1}, // R8 A
    {2'b00,2'b00,2'b00,2'b00,2'b01,2'b00, 8'h06, 6'h00, 1'b0}, // R8 B
    {2'b00,2'b00,2'b00,2'b00,2'b01,2'b00, 8'h06, 6'h00, 1'b0}  // R8 idle no effect
  };

  task automatic chk(input string tag, input logic [7:0] v, input logic [5:0] p, input logic i);
    checks++;
    if (vector !== v || pending !== p || irq !== i) begin
      failures++;
      $display("FAIL %s: vector=%h pending=%h irq=%b expected vector=%h pending=%h irq=%b",
               tag, vector, pending, irq, v, p, i);
    end
  endtask

  task automatic step(input logic [11:0] s);
    @(negedge clk);
    {ev_rx, ev_tx, cmd_clr_rx, cmd_clr_tx, cmd_rst_ius, vec_hi} = s;
    @(posedge clk); #1;
    {ev_rx, ev_tx, cmd_clr_rx, cmd_clr_tx, cmd_rst_ius} = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    chk("R1 reset state", 8'h00, 6'h00, 1'b0);
    @(negedge clk) rst = 1'b0;
    for (int k = 0; k < 18; k++) begin
      step(TBL[k][26:15]);
      chk($sformatf("R3 R4 R5 R6 R7 R8 R9 table row %0d", k), TBL[k][14:7], TBL[k][6:1], TBL[k][0]);
    end
    // R2 receive mode gating
    @(negedge clk) rx_mode_a = 2'b00;
    step(12'b10_00_00_00_00_00);
    chk("R2 mode 00 no irq", 8'h0C, 6'h20, 1'b0);
    @(negedge clk) rx_mode_a = 2'b11;
    @(posedge clk); #1;
    chk("R2 mode 11 no irq", 8'h0C, 6'h20, 1'b0);
    @(negedge clk) rx_mode_a = 2'b10;
    @(posedge clk); #1;
    chk("R2 mode 10 irq", 8'h0C, 6'h20, 1'b1);
    step(12'b00_00_10_00_00_00);
    chk("R7 clear A rx", 8'h06, 6'h00, 1'b0);
    // R2 transmit enable gating
    @(negedge clk) tx_int_en = 2'b00;
    step(12'b00_01_00_00_00_00);
    chk("R2 tx disabled", 8'h00, 6'h02, 1'b0);
    step(12'b00_00_00_01_00_00);
    chk("R7 clear B tx", 8'h06, 6'h00, 1'b0);
    // R2 break
    @(negedge clk) begin brk_int_en = 2'b10; brk_st = 2'b10; end
    @(posedge clk); #1;
    chk("R2 break irq", 8'h06, 6'h00, 1'b1);
    @(negedge clk) brk_int_en = 2'b00;
    @(posedge clk); #1;
    chk("R2 break masked", 8'h06, 6'h00, 1'b0);
    @(negedge clk) brk_st = 2'b00;
    // R1 reset mid-operation
    @(negedge clk) tx_int_en = 2'b11;
    step(12'b10_01_00_00_00_00);
    chk("R9 both channels", 8'h00, 6'h22, 1'b1);
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 reset clears", 8'h00, 6'h00, 1'b0);
    finish_run();
  end
endmodule